// File: doc/BRIEF.md
# MMU System-Control Register Bank

This block holds the system-control state of a small memory-management unit and is written and read through a coprocessor move interface. Each access carries a 32-bit instruction word, from which the block takes a register number, a secondary opcode (op2) and an auxiliary register field (CRm). It also carries a 32-bit data word. Writes update the control, translation-table base, domain access, fault status, fault address and process ID registers, each with its own field mask. Reads return the addressed register one cycle later.

A write to the TLB-maintenance register does not store anything. Instead it is decoded into one-cycle invalidate pulses for the instruction-side and data-side TLBs, and the written value is passed on as the address of a single-entry invalidate. A write to the translation base raises a strobe that flushes the table-walk caches. Writes to cache-operation, read-buffer, debug and unknown registers are accepted and discarded. An unrecognised TLB command raises an error pulse.

Top module: `mmu_cp_regs`

## Requirements
- R1: After reset, ctrl_o reads 0x00000070. ttb_o, dom_o, fsr_o, far_o, pid_o, rd_data_o and inv_addr_o read 0, and every pulse output is low.
- R2: The register number is instr_i[19:16], op2 is instr_i[7:5] and CRm is instr_i[3:0]; all other instruction bits are ignored. Register numbers are: 1 control, 2 translation base, 3 domain, 5 fault status, 6 fault address, 8 TLB maintenance, 13 process ID. A read with rd_en_i loads rd_data_o with the addressed register on the next clock edge.
- R3: A control write stores (wdata | 0x70) & 0x0000FFFD, so bits 6:4 always read 1, and bit 1 and bits 31:16 always read 0.
- R4: A translation-base write stores wdata & 0xFFFFC000, and walk_flush_o is high for exactly the cycle after the write.
- R5: A fault-status write stores wdata & 0xFF. Fault-address, domain and process-ID writes store all 32 bits.
- R6: A TLB write with op2=0 and CRm=7 pulses both itlb_inv_all_o and dtlb_inv_all_o.
- R7: A TLB write with CRm=5 acts on the instruction side. op2=0 pulses itlb_inv_all_o. op2=1 pulses itlb_inv_ent_o and loads inv_addr_o with wdata. inv_addr_o changes only on an entry invalidate.
- R8: A TLB write with CRm=6 does the same on the data side: op2=0 pulses dtlb_inv_all_o, and op2=1 pulses dtlb_inv_ent_o and loads inv_addr_o.
- R9: Any other op2/CRm pair on a TLB write pulses cmd_err_o for one cycle. No invalidate pulse fires, and no register output changes.
- R10: Writes to registers 0, 4, 7, 9–12, 14 and 15 change no output. Reads of any register other than 1, 2, 3, 5, 6 and 13 return 0.
- R11: Every pulse output is high only in the cycle directly after the write that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write (move to coprocessor) |
| rd_en_i | input | 1 | Register read (move from coprocessor) |
| instr_i | input | 32 | Instruction word carrying register number, op2, CRm |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, registered |
| ctrl_o | output | 32 | Control register |
| ttb_o | output | 32 | Translation-table base |
| dom_o | output | 32 | Domain access control |
| fsr_o | output | 32 | Fault status |
| far_o | output | 32 | Fault address |
| pid_o | output | 32 | Process ID |
| itlb_inv_all_o | output | 1 | Invalidate whole instruction TLB |
| itlb_inv_ent_o | output | 1 | Invalidate one instruction-TLB entry |
| dtlb_inv_all_o | output | 1 | Invalidate whole data TLB |
| dtlb_inv_ent_o | output | 1 | Invalidate one data-TLB entry |
| inv_addr_o | output | 32 | Address for entry invalidate |
| walk_flush_o | output | 1 | Flush table-walk caches |
| cmd_err_o | output | 1 | Unrecognised TLB command |

## Verification
Every result of this block is due exactly one clock edge after the access that causes it. This covers register updates, read data, invalidate pulses, the flush strobe and the error flag. The driver applies each access on a falling edge and queues the full expected output state, tagged with the cycle number one edge later. The monitor compares on the falling edge of that cycle, so a pulse that comes early, comes late or lasts two cycles shows up as a mismatch. Idle accesses between commands are also checked, to confirm that the pulses have dropped and the registers are holding their values.

// File: rtl/mmu_cp_pkg.sv
package mmu_cp_pkg;
  localparam int unsigned RNUM_W   = 4;
  localparam int unsigned OP2_W    = 3;
  localparam int unsigned CRM_W    = 4;
  localparam int unsigned RNUM_LSB = 16;
  localparam int unsigned OP2_LSB  = 5;
  localparam int unsigned CRM_LSB  = 0;
  localparam int unsigned N_SIDE   = 2;  // 0: instruction, 1: data

  typedef logic [RNUM_W-1:0] rnum_t;
  typedef logic [OP2_W-1:0]  op2_t;
  typedef logic [CRM_W-1:0]  crm_t;

  localparam rnum_t RN_CTRL = 4'd1;
  localparam rnum_t RN_TTB  = 4'd2;
  localparam rnum_t RN_DOM  = 4'd3;
  localparam rnum_t RN_FSR  = 4'd5;
  localparam rnum_t RN_FAR  = 4'd6;
  localparam rnum_t RN_TLB  = 4'd8;
  localparam rnum_t RN_PID  = 4'd13;

  localparam op2_t OP2_ALL = 3'd0;
  localparam op2_t OP2_ENT = 3'd1;
  localparam crm_t CRM_BOTH = 4'd7;
  localparam crm_t CRM_SIDE [N_SIDE] = '{4'd5, 4'd6};

  typedef struct packed {
    rnum_t rnum;
    op2_t  op2;
    crm_t  crm;
  } cp_fields_t;
endpackage

// File: rtl/mmu_cp_decode.sv
module mmu_cp_decode
  import mmu_cp_pkg::*;
#(
  parameter int unsigned IW = 32
) (
  input  logic [IW-1:0] instr_i,
  output cp_fields_t    fld_o
);
  localparam logic [IW-1:0] ONE = 1;
  localparam logic [IW-1:0] USED = (((ONE << RNUM_W) - ONE) << RNUM_LSB)
                                 | (((ONE << OP2_W) - ONE) << OP2_LSB)
                                 | (((ONE << CRM_W) - ONE) << CRM_LSB);

  assign fld_o.rnum = instr_i[RNUM_LSB +: RNUM_W];
  assign fld_o.op2  = instr_i[OP2_LSB +: OP2_W];
  assign fld_o.crm  = instr_i[CRM_LSB +: CRM_W];

  logic unused_instr;
  assign unused_instr = ^(instr_i & ~USED);
endmodule

// File: rtl/mmu_cp_tlb_cmd.sv
module mmu_cp_tlb_cmd
  import mmu_cp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  op2_t              op2_i,
  input  crm_t              crm_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [N_SIDE-1:0] inv_all_o,
  output logic [N_SIDE-1:0] inv_ent_o,
  output logic [DW-1:0]     inv_addr_o,
  output logic              err_o
);
  logic [N_SIDE-1:0] all_d, ent_d;
  logic              err_d;

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    assign all_d[s] = req_i && (op2_i == OP2_ALL)
                      && ((crm_i == CRM_SIDE[s]) || (crm_i == CRM_BOTH));
    assign ent_d[s] = req_i && (op2_i == OP2_ENT) && (crm_i == CRM_SIDE[s]);
  end

  assign err_d = req_i && !(|all_d) && !(|ent_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_all_o  <= '0;
      inv_ent_o  <= '0;
      inv_addr_o <= '0;
      err_o      <= 1'b0;
    end else begin
      inv_all_o <= all_d;
      inv_ent_o <= ent_d;
      err_o     <= err_d;
      if (|ent_d) inv_addr_o <= wdata_i;
    end
  end
endmodule

// File: rtl/mmu_cp_bank.sv
module mmu_cp_bank
  import mmu_cp_pkg::*;
#(
  parameter int unsigned     DW        = 32,
  parameter int unsigned     TTB_LO    = 14,
  parameter int unsigned     FSR_W     = 8,
  parameter logic [DW-1:0]   CTRL_SET  = 32'h0000_0070,
  parameter logic [DW-1:0]   CTRL_KEEP = 32'h0000_FFFD
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  cp_fields_t    fld_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] ttb_o,
  output logic [DW-1:0] dom_o,
  output logic [DW-1:0] fsr_o,
  output logic [DW-1:0] far_o,
  output logic [DW-1:0] pid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          flush_o
);
  localparam logic [DW-1:0] ONE      = 1;
  localparam logic [DW-1:0] TTB_MASK = ~((ONE << TTB_LO) - ONE);
  localparam logic [DW-1:0] FSR_MASK = (ONE << FSR_W) - ONE;

  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= CTRL_SET & CTRL_KEEP;
      ttb_o   <= '0;
      dom_o   <= '0;
      fsr_o   <= '0;
      far_o   <= '0;
      pid_o   <= '0;
      flush_o <= 1'b0;
    end else begin
      flush_o <= wr_i && (fld_i.rnum == RN_TTB);
      if (wr_i) begin
        unique case (fld_i.rnum)
          RN_CTRL: ctrl_o <= (wdata_i | CTRL_SET) & CTRL_KEEP;
          RN_TTB:  ttb_o  <= wdata_i & TTB_MASK;
          RN_DOM:  dom_o  <= wdata_i;
          RN_FSR:  fsr_o  <= wdata_i & FSR_MASK;
          RN_FAR:  far_o  <= wdata_i;
          RN_PID:  pid_o  <= wdata_i;
          default: ;  // cache, TLB, read buffer, debug, unknown: no storage
        endcase
      end
    end
  end

  always_comb begin
    unique case (fld_i.rnum)
      RN_CTRL: rd_mux = ctrl_o;
      RN_TTB:  rd_mux = ttb_o;
      RN_DOM:  rd_mux = dom_o;
      RN_FSR:  rd_mux = fsr_o;
      RN_FAR:  rd_mux = far_o;
      RN_PID:  rd_mux = pid_o;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= '0;
    else if (rd_i) rd_data_o <= rd_mux;
  end
endmodule

// File: rtl/mmu_cp_regs.sv
module mmu_cp_regs
  import mmu_cp_pkg::*;
#(
  parameter int unsigned IW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [IW-1:0] instr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] ttb_o,
  output logic [DW-1:0] dom_o,
  output logic [DW-1:0] fsr_o,
  output logic [DW-1:0] far_o,
  output logic [DW-1:0] pid_o,
  output logic          itlb_inv_all_o,
  output logic          itlb_inv_ent_o,
  output logic          dtlb_inv_all_o,
  output logic          dtlb_inv_ent_o,
  output logic [DW-1:0] inv_addr_o,
  output logic          walk_flush_o,
  output logic          cmd_err_o
);
  cp_fields_t        fld;
  logic [N_SIDE-1:0] inv_all, inv_ent;

  mmu_cp_decode #(.IW(IW)) u_dec (
    .instr_i (instr_i),
    .fld_o   (fld)
  );

  mmu_cp_bank #(.DW(DW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i),
    .rd_i      (rd_en_i),
    .fld_i     (fld),
    .wdata_i   (wdata_i),
    .ctrl_o    (ctrl_o),
    .ttb_o     (ttb_o),
    .dom_o     (dom_o),
    .fsr_o     (fsr_o),
    .far_o     (far_o),
    .pid_o     (pid_o),
    .rd_data_o (rd_data_o),
    .flush_o   (walk_flush_o)
  );

  mmu_cp_tlb_cmd #(.DW(DW)) u_tlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (wr_en_i && (fld.rnum == RN_TLB)),
    .op2_i      (fld.op2),
    .crm_i      (fld.crm),
    .wdata_i    (wdata_i),
    .inv_all_o  (inv_all),
    .inv_ent_o  (inv_ent),
    .inv_addr_o (inv_addr_o),
    .err_o      (cmd_err_o)
  );

  assign itlb_inv_all_o = inv_all[0];
  assign dtlb_inv_all_o = inv_all[1];
  assign itlb_inv_ent_o = inv_ent[0];
  assign dtlb_inv_ent_o = inv_ent[1];
endmodule

// File: rtl/mmu_cp_regs_chk.sv
module mmu_cp_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] instr_i,
  input logic [31:0] ctrl_o,
  input logic [31:0] ttb_o,
  input logic [31:0] fsr_o,
  input logic [31:0] inv_addr_o,
  input logic        itlb_inv_all_o,
  input logic        itlb_inv_ent_o,
  input logic        dtlb_inv_all_o,
  input logic        dtlb_inv_ent_o,
  input logic        walk_flush_o,
  input logic        cmd_err_o
);
  logic tlb_wr, ttb_wr;
  logic [4:0] inv_vec;
  assign tlb_wr  = wr_en_i && (instr_i[19:16] == 4'd8);
  assign ttb_wr  = wr_en_i && (instr_i[19:16] == 4'd2);
  assign inv_vec = {itlb_inv_all_o, itlb_inv_ent_o, dtlb_inv_all_o, dtlb_inv_ent_o, walk_flush_o};

  AST_CTRL_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[6:4] == 3'b111 && !ctrl_o[1] && ctrl_o[31:16] == 16'h0); // R3
  AST_TTB_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ttb_o[13:0] == 14'h0); // R4
  AST_WALK_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ttb_wr |=> walk_flush_o); // R4
  AST_FSR_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsr_o[31:8] == 24'h0); // R5
  AST_INV_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_wr && instr_i[7:5] == 3'd0 && instr_i[3:0] == 4'd7
    |=> itlb_inv_all_o && dtlb_inv_all_o); // R6
  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> !itlb_inv_all_o && !itlb_inv_ent_o && !dtlb_inv_all_o && !dtlb_inv_ent_o); // R9
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> $stable(ctrl_o) && $stable(ttb_o) && $stable(inv_addr_o)); // R9
  AST_PULSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> inv_vec == 5'b0 && !cmd_err_o); // R11
  AST_ONE_HOT_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({itlb_inv_ent_o, dtlb_inv_ent_o, cmd_err_o})); // R7
endmodule

bind mmu_cp_regs mmu_cp_regs_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .instr_i        (instr_i),
  .ctrl_o         (ctrl_o),
  .ttb_o          (ttb_o),
  .fsr_o          (fsr_o),
  .inv_addr_o     (inv_addr_o),
  .itlb_inv_all_o (itlb_inv_all_o),
  .itlb_inv_ent_o (itlb_inv_ent_o),
  .dtlb_inv_all_o (dtlb_inv_all_o),
  .dtlb_inv_ent_o (dtlb_inv_ent_o),
  .walk_flush_o   (walk_flush_o),
  .cmd_err_o      (cmd_err_o)
);

// File: tb/sim_mmu_cp_regs.sv
module sim_mmu_cp_regs;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 8 * 32 + 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] instr = '0, wdata = '0;
  logic [31:0] rd_data, ctrl, ttb, dom, fsr, far_r, pid, inv_addr;
  logic        ia, ie, da, de, flush, err;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mmu_cp_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .instr_i(instr), .wdata_i(wdata), .rd_data_o(rd_data),
    .ctrl_o(ctrl), .ttb_o(ttb), .dom_o(dom), .fsr_o(fsr), .far_o(far_r), .pid_o(pid),
    .itlb_inv_all_o(ia), .itlb_inv_ent_o(ie), .dtlb_inv_all_o(da), .dtlb_inv_ent_o(de),
    .inv_addr_o(inv_addr), .walk_flush_o(flush), .cmd_err_o(err)
  );

  typedef struct {
    string       tag;
    int          due;
    logic [VW-1:0] v;
  } exp_t;

  exp_t q[$];
  int   cyc = 0, total = 0, bad = 0;
  bit   done = 1'b0;

  logic [31:0] m_ctrl = 32'h70, m_ttb = 0, m_dom = 0, m_fsr = 0, m_far = 0, m_pid = 0;
  logic [31:0] m_rd = 0, m_inv = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk(logic [3:0] r, logic [2:0] o, logic [3:0] c,
                                     logic [11:0] hi = 12'h0, logic [7:0] mid = 8'h0);
    return {hi, r, mid, o, 1'b0, c};
  endfunction

  function automatic logic [31:0] rv(logic [3:0] r);
    case (r)
      4'd1: return m_ctrl;
      4'd2: return m_ttb;
      4'd3: return m_dom;
      4'd5: return m_fsr;
      4'd6: return m_far;
      4'd13: return m_pid;
      default: return 32'h0;
    endcase
  endfunction

  task automatic op(input string tag, input bit w, input bit r,
                    input logic [31:0] ins, input logic [31:0] d);
    logic [5:0] p;
    logic [3:0] rn;
    logic [2:0] o2;
    logic [3:0] cm;
    exp_t e;
    @(negedge clk);
    wr_en = w; rd_en = r; instr = ins; wdata = d;
    rn = ins[19:16]; o2 = ins[7:5]; cm = ins[3:0];
    p = '0;  // {ia, ie, da, de, flush, err}
    if (r) m_rd = rv(rn);
    if (w) begin
      case (rn)
        4'd1: m_ctrl = (d | 32'h70) & 32'h0000FFFD;
        4'd2: begin m_ttb = d & 32'hFFFFC000; p[1] = 1'b1; end
        4'd3: m_dom = d;
        4'd5: m_fsr = d & 32'hFF;
        4'd6: m_far = d;
        4'd13: m_pid = d;
        4'd8: begin
          if (o2 == 0 && cm == 7) begin p[5] = 1; p[3] = 1; end
          else if (o2 == 0 && cm == 5) p[5] = 1;
          else if (o2 == 1 && cm == 5) begin p[4] = 1; m_inv = d; end
          else if (o2 == 0 && cm == 6) p[3] = 1;
          else if (o2 == 1 && cm == 6) begin p[2] = 1; m_inv = d; end
          else p[0] = 1;
        end
        default: ;
      endcase
    end
    e.tag = tag;
    e.due = cyc + 1;
    e.v = {m_ctrl, m_ttb, m_dom, m_fsr, m_far, m_pid, m_rd, m_inv, p};
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      logic [VW-1:0] a;
      e = q.pop_front();
      a = {ctrl, ttb, dom, fsr, far_r, pid, rd_data, inv_addr, ia, ie, da, de, flush, err};
      total++;
      if (a !== e.v) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", e.tag, a, e.v);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    op("R1 reset state", 0, 0, 0, 0);
    op("R3 ctrl all ones", 1, 0, mk(1, 0, 0), 32'hFFFF_FFFF);
    op("R3 ctrl bit1 forced low", 1, 0, mk(1, 0, 0), 32'h0000_0002);
    op("R3 ctrl readback", 0, 1, mk(1, 0, 0), 0);
    op("R4 ttb aligned + flush", 1, 0, mk(2, 0, 0), 32'h1234_5678);
    op("R11 flush drops", 0, 0, 0, 0);
    op("R5 domain full", 1, 0, mk(3, 0, 0), 32'hDEAD_BEEF);
    op("R5 fsr low byte", 1, 0, mk(5, 0, 0), 32'hCAFE_1234);
    op("R5 far full", 1, 0, mk(6, 0, 0), 32'h89AB_CDEF);
    op("R5 pid full", 1, 0, mk(13, 0, 0), 32'h0200_0000);
    op("R2 read ttb junk bits", 0, 1, mk(2, 3'd5, 4'd9, 12'hEE0, 8'hAA), 0);
    op("R2 read fsr", 0, 1, mk(5, 0, 0), 0);
    op("R2 read far", 0, 1, mk(6, 0, 0), 0);
    op("R2 read pid", 0, 1, mk(13, 0, 0), 0);
    op("R2 read dom", 0, 1, mk(3, 0, 0), 0);
    op("R6 inval both", 1, 0, mk(8, 0, 7), 32'h5555_0000);
    op("R11 idle after inval", 0, 0, 0, 0);
    op("R7 itlb all", 1, 0, mk(8, 0, 5), 32'h1111_0000);
    op("R7 itlb entry", 1, 0, mk(8, 1, 5), 32'h4000_1000);
    op("R8 dtlb all", 1, 0, mk(8, 0, 6), 32'h2222_0000);
    op("R8 dtlb entry", 1, 0, mk(8, 1, 6), 32'h8000_2000);
    op("R2 dtlb entry junk bits", 1, 0, mk(8, 1, 6, 12'hFFF, 8'hFF), 32'h0000_3000);
    op("R9 bad op2", 1, 0, mk(8, 2, 5), 32'hFFFF_FFFF);
    op("R9 bad crm", 1, 0, mk(8, 0, 8), 32'hFFFF_FFFF);
    op("R9 entry with crm7", 1, 0, mk(8, 1, 7), 32'hFFFF_FFFF);
    op("R11 idle after err", 0, 0, 0, 0);
    op("R10 cache reg write", 1, 0, mk(7, 0, 5), 32'hFFFF_FFFF);
    op("R10 readbuf write", 1, 0, mk(9, 0, 0), 32'hFFFF_FFFF);
    op("R10 debug write", 1, 0, mk(14, 0, 0), 32'hFFFF_FFFF);
    op("R10 reg15 write", 1, 0, mk(15, 0, 0), 32'hFFFF_FFFF);
    op("R10 reg0 write", 1, 0, mk(0, 0, 0), 32'hFFFF_FFFF);
    op("R10 read reg0", 0, 1, mk(0, 0, 0), 0);
    op("R10 read reg8", 0, 1, mk(8, 0, 0), 0);
    op("R10 read ctrl again", 0, 1, mk(1, 0, 0), 0);
    op("R10 read reg12", 0, 1, mk(12, 0, 0), 0);
    op("R3 ctrl zero", 1, 0, mk(1, 0, 0), 32'h0);
    op("R4 ttb low bits only", 1, 0, mk(2, 0, 0), 32'h0000_3FFF);
    op("R11 final idle", 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R11 pending items: actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule